// File: doc/BRIEF.md
# Parallel Memory Configuration Byte Loader

This block reads configuration bytes from an external byte-wide memory and turns them into a continuous serial bit stream. It holds the 18-bit memory address itself and emits a read clock; each rising read-clock edge latches one byte. Each byte then leaves on a single data pin, least significant bit first. The block also drives the serial clock that goes with that pin, so that further devices in a daisy chain can take the stream.

A start pulse samples the direction input and the byte-count limit. In up mode the address begins at zero and rises by one per byte. In down mode it begins at the top of the 18-bit space and falls by one per byte. Both clocks come from the system clock through a divider. The serial clock runs at exactly eight times the read clock, and every read-clock rise coincides with the start of a serial bit period. A holding register takes the next byte while the current one shifts, so bytes follow each other without a gap.

The stream runs at a fixed rate set by the divider and has no valid/ready handshake. The memory must answer one system cycle after the address changes, and it cannot apply back-pressure. Downstream devices cannot stall the stream either. After the programmed number of bytes the block raises done and holds both clocks low.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset, mem_addr is 0, rd_clk, ser_clk and ser_dout are low, and done is low.
- R2: With dir_down low at start, the first address is 0x00000, and the address increments by one right after each read-clock rise. The address wraps modulo 2^18.
- R3: With dir_down high at start, the first address is 0x3FFFF, and the address decrements by one right after each read-clock rise. The address wraps modulo 2^18.
- R4: Each rd_clk rise captures the byte the memory returns for the current address, assuming one cycle of memory latency. The first rise comes two system cycles after the start pulse is accepted. rd_clk rises exactly byte_limit times per run. It stays high for four serial bit periods and low for four.
- R5: Each byte leaves on ser_dout with bit 0 first and bit 7 last, one bit per serial clock period.
- R6: One serial bit period lasts 2*HALF_DIV system cycles. ser_clk is low for the first HALF_DIV cycles and high for the rest, which gives eight serial clock periods per read clock period.
- R7: ser_dout changes only in cycles where ser_clk is low, that is, together with a falling serial-clock edge or before the first rising one.
- R8: Byte k (counting from 0) is shifted during byte period k+1 after start. Consecutive bytes follow with no idle serial periods.
- R9: After byte_limit bytes have shifted, done rises at the start of the next byte period. rd_clk, ser_clk and ser_dout then stay low, and mem_addr holds the first address moved by byte_limit.
- R10: A start pulse is accepted only while idle or done. Pulses during a run do not change the stream, the direction or the byte count.
- R11: A byte_limit of 0 produces no read-clock edge and no serial clock, and done rises one byte period after the run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a load when idle or done |
| dir_down | input | 1 | Address direction sampled at start: 1 counts down from the top |
| mem_data | input | 8 | Byte returned by the memory |
| byte_limit | input | 18 | Number of bytes to transfer, sampled at start |
| mem_addr | output | 18 | Memory address |
| rd_clk | output | 1 | Read clock; the rising edge captures a byte |
| ser_clk | output | 1 | Serial clock for daisy-chained devices |
| ser_dout | output | 1 | Serial data, valid on the ser_clk rising edge |
| done | output | 1 | Load finished; the clocks are stopped |

## Verification
The bound checker watches four relations on every cycle. The address moves by exactly one step, in the latched direction, at each read-clock rise. The serial data never changes while the serial clock is high. Every full byte period holds exactly eight serial-clock rises. Both clocks and the data line are silent whenever done is high. Other properties can only be shown by the bench's scenarios: which bytes reach the line and in what bit order, that the byte count is honoured (including zero), that a start pulse during a run is ignored, and that a restart from done begins at the correct base address.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } cbl_state_e;
endpackage

// File: rtl/cbl_timebase.sv
// Divides the system clock into serial bit slots and byte periods.
// Produces the position that will hold after the coming edge.
module cbl_timebase #(
  parameter int HALF_DIV = 2,
  parameter int SLOTS    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       adv,
  output logic [$clog2(SLOTS)-1:0]   slot_n,
  output logic                       hi_n,
  output logic                       slot_start_n,
  output logic                       period_start_n
);
  localparam int T  = 2 * HALF_DIV;
  localparam int CW = (T > 2) ? $clog2(T) : 1;
  localparam int SW = $clog2(SLOTS);

  logic [CW-1:0] cyc_q, cyc_n;
  logic [SW-1:0] slot_q;
  logic          cyc_last, slot_last;

  assign cyc_last  = (cyc_q == CW'(T - 1));
  assign slot_last = (slot_q == SW'(SLOTS - 1));

  always_comb begin
    cyc_n          = cyc_q;
    slot_n         = slot_q;
    slot_start_n   = 1'b0;
    period_start_n = 1'b0;
    if (clr) begin
      cyc_n          = '0;
      slot_n         = '0;
      slot_start_n   = 1'b1;
      period_start_n = 1'b1;
    end else if (adv) begin
      if (cyc_last) begin
        cyc_n          = '0;
        slot_n         = slot_last ? '0 : slot_q + 1'b1;
        slot_start_n   = 1'b1;
        period_start_n = slot_last;
      end else begin
        cyc_n = cyc_q + 1'b1;
      end
    end
  end

  assign hi_n = (cyc_n >= CW'(HALF_DIV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_n;
      slot_q <= slot_n;
    end
  end
endmodule

// File: rtl/cbl_fetch.sv
// Address counter and holding register for the prefetched byte.
module cbl_fetch #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic          base_down,
  input  logic          fetch,
  input  logic          step_down,
  input  logic [DW-1:0] mem_data,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hold_q <= '0;
    end else if (load_base) begin
      addr_q <= base_down ? {AW{1'b1}} : '0;
    end else if (fetch) begin
      hold_q <= mem_data;
      addr_q <= step_down ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbl_serializer.sv
// Shift register emitting bit 0 first; output is registered.
module cbl_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          active_n,
  input  logic [DW-1:0] par_in,
  output logic          dout_q
);
  logic [DW-1:0] sh_q, sh_n;

  always_comb begin
    if (load)       sh_n = par_in;
    else if (shift) sh_n = {1'b0, sh_q[DW-1:1]};
    else            sh_n = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      dout_q <= active_n & sh_n[0];
    end
  end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_down,
  input  logic [DW-1:0] mem_data,
  input  logic [AW-1:0] byte_limit,
  output logic [AW-1:0] mem_addr,
  output logic          rd_clk,
  output logic          ser_clk,
  output logic          ser_dout,
  output logic          done
);
  import cbl_pkg::*;

  localparam int SW   = $clog2(DW);
  localparam int CNTW = AW + 1;

  cbl_state_e      state_q, state_n;
  logic            prime_q;
  logic            dir_q;
  logic [CNTW-1:0] per_q, per_n, lim_q;
  logic            accept, enter_run, pstart, fetch, load, running_n, active_n;
  logic [SW-1:0]   slot_n;
  logic            hi_n, slot_start_n, period_start_n;
  logic [DW-1:0]   hold;
  logic            rd_clk_q, ser_clk_q, done_q;

  assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign enter_run = (state_q == ST_PRIME) && prime_q;

  cbl_timebase #(.HALF_DIV(HALF_DIV), .SLOTS(DW)) u_tb (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (enter_run),
    .adv            (state_q == ST_RUN),
    .slot_n         (slot_n),
    .hi_n           (hi_n),
    .slot_start_n   (slot_start_n),
    .period_start_n (period_start_n)
  );

  assign pstart = enter_run || ((state_q == ST_RUN) && period_start_n);

  always_comb begin
    if (enter_run)   per_n = '0;
    else if (pstart) per_n = per_q + 1'b1;
    else             per_n = per_q;
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (accept) state_n = ST_PRIME;
      ST_PRIME:         if (prime_q) state_n = ST_RUN;
      ST_RUN:           if (pstart && per_n == lim_q + 1'b1) state_n = ST_DONE;
      default:          state_n = ST_IDLE;
    endcase
  end

  assign running_n = (state_n == ST_RUN);
  assign fetch     = pstart && running_n && (per_n < lim_q);
  assign load      = pstart && running_n && (per_n != '0) && (per_n <= lim_q);
  assign active_n  = running_n && (per_n != '0) && (per_n <= lim_q);

  cbl_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_base (accept),
    .base_down (dir_down),
    .fetch     (fetch),
    .step_down (dir_q),
    .mem_data  (mem_data),
    .addr_q    (mem_addr),
    .hold_q    (hold)
  );

  cbl_serializer #(.DW(DW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (slot_start_n),
    .active_n (active_n),
    .par_in   (hold),
    .dout_q   (ser_dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      prime_q   <= 1'b0;
      dir_q     <= 1'b0;
      per_q     <= '0;
      lim_q     <= '0;
      rd_clk_q  <= 1'b0;
      ser_clk_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      prime_q   <= (state_q == ST_PRIME) && !accept;
      per_q     <= per_n;
      if (accept) begin
        dir_q <= dir_down;
        lim_q <= {1'b0, byte_limit};
      end
      rd_clk_q  <= running_n && (per_n < lim_q) && (slot_n < SW'(DW / 2));
      ser_clk_q <= active_n && hi_n;
      done_q    <= (state_n == ST_DONE);
    end
  end

  assign rd_clk  = rd_clk_q;
  assign ser_clk = ser_clk_q;
  assign done    = done_q;
endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          rd_clk,
  input logic          ser_clk,
  input logic          ser_dout,
  input logic          done,
  input logic          dir_q
);
  logic       rd_prev, ser_prev;
  logic [7:0] ser_rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= 1'b0;
      ser_prev  <= 1'b0;
      ser_rises <= '0;
    end else begin
      rd_prev  <= rd_clk;
      ser_prev <= ser_clk;
      if (done || (rd_clk && !rd_prev)) ser_rises <= '0;
      else if (ser_clk && !ser_prev)    ser_rises <= ser_rises + 1'b1;
    end
  end

  // R2 R3: one address step per captured byte, in the latched direction
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_clk) |-> (mem_addr == (dir_q ? AW'($past(mem_addr) - 1'b1)
                                          : AW'($past(mem_addr) + 1'b1))));

  // R7: data only moves while the serial clock is low
  p_dout_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> !ser_clk);

  // R6: eight serial clock rises per byte period (zero for the priming period)
  p_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clk && !rd_prev) |-> (ser_rises == 8'(0) || ser_rises == 8'(DW)));

  // R9: everything quiet once done
  p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_clk && !ser_clk && !ser_dout));
endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .rd_clk   (rd_clk),
  .ser_clk  (ser_clk),
  .ser_dout (ser_dout),
  .done     (done),
  .dir_q    (dir_q)
);

// File: tb/cfg_byte_loader_test.sv
module cfg_byte_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HD         = 2;
  localparam int PER        = 8 * 2 * HD;
  localparam int MASK       = 'h3FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_down = 1'b0;
  logic [7:0]  mem_data = 8'h00;
  logic [17:0] byte_limit = '0;
  logic [17:0] mem_addr;
  logic        rd_clk, ser_clk, ser_dout, done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  cfg_byte_loader #(.AW(18), .DW(8), .HALF_DIV(HD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
    .mem_data(mem_data), .byte_limit(byte_limit), .mem_addr(mem_addr),
    .rd_clk(rd_clk), .ser_clk(ser_clk), .ser_dout(ser_dout), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [17:0] a);
    return 8'(a[7:0] * 8'd37 + 8'd11) ^ a[17:10];
  endfunction

  // memory with one cycle of read latency
  always @(posedge clk) mem_data <= mem_fn(mem_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0;   // 0 idle, 1 prime, 2 run, 3 done
  int m_pc = 0, m_g = 0, m_base = 0, m_lim = 0;
  bit m_dn = 0;

  function automatic int addr_of(input int k);
    return m_dn ? ((m_base - k) & MASK) : ((m_base + k) & MASK);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0;
    end else begin
      case (m_st)
        0, 3: if (start) begin
          m_st = 1; m_pc = 0; m_dn = dir_down;
          m_base = dir_down ? MASK : 0; m_lim = int'(byte_limit);
        end
        1: if (m_pc == 1) begin m_st = 2; m_g = 0; end else m_pc++;
        default: begin
          m_g++;
          if (m_g / PER == m_lim + 1) m_st = 3;
        end
      endcase
    end
  end

  // per-cycle comparison, collector of serial bytes
  bit        cmp_on = 0;
  bit        ser_prev = 0, rd_prev = 0;
  logic [7:0] col = 0;
  int        nbits = 0, ser_edges = 0, rd_edges = 0;
  logic [7:0] got[$];

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int ea, er, es, ed, en;
      ea = 0; er = 0; es = 0; ed = 0; en = 0;
      if (m_st == 1) ea = m_base;
      else if (m_st == 3) begin ea = addr_of(m_lim); en = 1; end
      else if (m_st == 2) begin
        int p, c, s;
        p = m_g / PER; c = m_g % PER; s = c / (2 * HD);
        ea = (p < m_lim) ? addr_of(p + 1) : addr_of(m_lim);
        er = (p < m_lim && s < 4) ? 1 : 0;
        if (p >= 1 && p <= m_lim) begin
          es = ((c % (2 * HD)) >= HD) ? 1 : 0;
          ed = int'((mem_fn(18'(addr_of(p - 1))) >> s) & 8'd1);
        end
      end
      check(int'(mem_addr) == ea, "R2 R3 address", int'(mem_addr), ea);
      check(int'(rd_clk) == er, "R4 read clock", int'(rd_clk), er);
      check(int'(ser_clk) == es, "R6 serial clock", int'(ser_clk), es);
      check(int'(ser_dout) == ed, "R5 R7 R8 serial data", int'(ser_dout), ed);
      check(int'(done) == en, "R9 done", int'(done), en);
    end
    if (ser_clk && !ser_prev) begin
      ser_edges++;
      col = {ser_dout, col[7:1]};
      nbits++;
      if (nbits == 8) begin got.push_back(col); nbits = 0; end
    end
    if (rd_clk && !rd_prev) rd_edges++;
    ser_prev = ser_clk;
    rd_prev  = rd_clk;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      finish_up();
    end
  end

  task automatic run_case(input bit d, input int lim, input bit poke);
    int base;
    got.delete(); nbits = 0; ser_edges = 0; rd_edges = 0;
    @(negedge clk);
    start = 1; dir_down = d; byte_limit = 18'(lim);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1; dir_down = ~d; byte_limit = 18'(lim + 3);
      @(negedge clk);
      start = 0; dir_down = d;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    base = d ? MASK : 0;
    // R8 R9: byte count; R10 when a start was poked mid-run
    check(got.size() == lim, poke ? "R10 byte count" : "R8 R9 byte count", got.size(), lim);
    check(rd_edges == lim, lim == 0 ? "R11 read edges" : "R4 read edges", rd_edges, lim);
    check(ser_edges == 8 * lim, "R6 serial edges", ser_edges, 8 * lim);
    foreach (got[k]) begin
      int a;
      a = d ? ((base - k) & MASK) : ((base + k) & MASK);
      check(got[k] == mem_fn(18'(a)), "R5 byte content LSB first", int'(got[k]), int'(mem_fn(18'(a))));
    end
    check(int'(mem_addr) == (d ? ((base - lim) & MASK) : lim), "R9 final address",
          int'(mem_addr), d ? ((base - lim) & MASK) : lim);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_addr == 18'd0, "R1 reset address", int'(mem_addr), 0);
    check({rd_clk, ser_clk, ser_dout, done} == 4'b0, "R1 reset outputs",
          int'({rd_clk, ser_clk, ser_dout, done}), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    run_case(1'b0, 3, 1'b0);   // R2 up count
    run_case(1'b1, 2, 1'b0);   // R3 down count, restart from done
    run_case(1'b0, 0, 1'b0);   // R11 empty load
    run_case(1'b0, 4, 1'b1);   // R10 start ignored while busy
    run_case(1'b1, 1, 1'b0);   // single byte from the top
    finish_up();
  end
endmodule